// File: doc/BRIEF.md
# Six-Channel Broadcast Serial Transmitter

This block sends one byte, framed for an asynchronous serial line, on any subset of six output lines at once. The host issues one 16-bit write to the transmit address: the low byte is the payload and six select bits name the lines that carry it. The frame starts on the clock edge that takes the write; no separate start command exists. Lines that are not selected stay at the idle-high level throughout.

Each line has its own bit-period register, written at its own address. The register holds a divider count: the number of clock cycles per bit. When several lines are selected, one frame timing is shared by all of them, and it is taken from the smallest divider among them, which is the fastest rate. A single shift engine serializes the frame. Per-line output gating sends either the engine's bit or a constant high level to each line.

A second transmit write that arrives during a frame waits in a one-slot holding buffer and is launched on the cycle the current frame ends. A further write that arrives while that slot is full is discarded.

Top module: `ser_bcast_tx`

## Requirements
- R1: A frame is one start bit at 0, then the eight payload bits `wr_data[7:0]` least significant bit first, then one stop bit at 1. Each bit lasts exactly D clock cycles, where D is the frame's divider.
- R2: Bit `wr_data[8+k]` (k = 0..5) selects line `tx_line[k]`. Every selected line carries the same frame. Every unselected line stays at 1.
- R3: Bits `wr_data[15:14]` of a transmit write have no effect on the frame or on line selection.
- R4: A transmit write (`wr_addr` = 0) with a nonzero selection, taken at a clock edge while idle, makes `tx_busy` 1 and drives the start bit on the selected lines in the cycle that follows that edge.
- R5: A write to `wr_addr` = k+1 (k = 0..5) sets the divider of line k to `wr_data[15:0]`. A divider value of 0 acts as 1.
- R6: When several lines are selected, D is the smallest of their dividers.
- R7: `tx_busy` stays high for exactly 10·D cycles for a single frame.
- R8: A transmit write taken while busy, with the holding slot empty, is sent right after the current frame. Its start bit appears in the first cycle after the last stop-bit cycle, and `tx_busy` stays high without a gap.
- R9: A transmit write taken while busy, with the holding slot already full, is discarded.
- R10: A transmit write with all six selection bits 0 sends nothing, leaves `tx_busy` low and does not occupy the holding slot.
- R11: After reset, all lines are 1, `tx_busy` is 0 and every divider holds the parameter `DIV_RST` (default 16).
- R12: A divider write during a frame does not change the bit timing of that frame. The frame's divider is fixed when the frame launches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | 3 | 0 is transmit; 1 to 6 are the line dividers |
| wr_data | input | 16 | Write data |
| tx_line | output | 6 | Serial lines, idle high |
| tx_busy | output | 1 | High while a frame is on the lines |

## Verification
The hardest state to reach from the ports is a full holding slot while a frame is in flight, and the exact edge where one frame ends and the held one begins. The bench gets there by running a frame check and a write sequence in parallel branches. During a slow frame it queues a second transmit, then a zero-selection write, then a third transmit. It then checks that the second frame starts in the cycle after the first one's stop bit with no idle gap, and that the third write never shows up on any line.

// File: rtl/ser_bcast_pkg.sv
package ser_bcast_pkg;
    localparam int FRAME_LEN = 10;
    localparam int IDX_W     = 4;
    localparam int BYTE_W    = 8;
    localparam int SEL_LSB   = 8;

    function automatic logic [FRAME_LEN-1:0] build_frame(input logic [BYTE_W-1:0] b);
        return {1'b1, b, 1'b0};
    endfunction
endpackage

// File: rtl/sbt_baud_bank.sv
module sbt_baud_bank #(
    parameter int NUM_CH  = 6,
    parameter int DIV_W   = 16,
    parameter int ADDR_W  = 3,
    parameter int DIV_RST = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [DIV_W-1:0]               wr_data,
    output logic [NUM_CH-1:0][DIV_W-1:0]   div_o
);
    typedef struct packed {
        logic [NUM_CH-1:0][DIV_W-1:0] div;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (wr_en && (wr_addr == ADDR_W'(i + 1))) begin
                st_d.div[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) begin
                st_q.div[i] <= DIV_W'(DIV_RST);
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign div_o = st_q.div;
endmodule

// File: rtl/sbt_div_pick.sv
module sbt_div_pick #(
    parameter int NUM_CH = 6,
    parameter int DIV_W  = 16
) (
    input  logic [NUM_CH-1:0]              sel_i,
    input  logic [NUM_CH-1:0][DIV_W-1:0]   div_i,
    output logic [DIV_W-1:0]               div_o
);
    logic [NUM_CH-1:0][DIV_W-1:0] eff;

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_clamp
            assign eff[g] = (div_i[g] == '0) ? DIV_W'(1) : div_i[g];
        end
    endgenerate

    always_comb begin
        div_o = '1;
        for (int i = 0; i < NUM_CH; i++) begin
            if (sel_i[i] && (eff[i] < div_o)) begin
                div_o = eff[i];
            end
        end
    end
endmodule

// File: rtl/sbt_shift_eng.sv
module sbt_shift_eng
    import ser_bcast_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic [DIV_W-1:0]  div_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              line_o
);
    typedef struct packed {
        logic                 busy;
        logic [DIV_W-1:0]     cnt;
        logic [IDX_W-1:0]     idx;
        logic [FRAME_LEN-1:0] frame;
        logic [DIV_W-1:0]     div;
    } eng_t;

    eng_t st_d, st_q;
    logic bit_end;

    always_comb begin
        st_d    = st_q;
        bit_end = st_q.busy && (st_q.cnt == st_q.div - DIV_W'(1));
        done_o  = bit_end && (st_q.idx == IDX_W'(FRAME_LEN - 1));
        if (st_q.busy) begin
            if (bit_end) begin
                st_d.cnt = '0;
                if (done_o) begin
                    st_d.busy = 1'b0;
                end else begin
                    st_d.idx   = st_q.idx + IDX_W'(1);
                    st_d.frame = {1'b1, st_q.frame[FRAME_LEN-1:1]};
                end
            end else begin
                st_d.cnt = st_q.cnt + DIV_W'(1);
            end
        end
        if (start_i) begin
            st_d.busy  = 1'b1;
            st_d.cnt   = '0;
            st_d.idx   = '0;
            st_d.frame = build_frame(data_i);
            st_d.div   = div_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.busy  <= 1'b0;
            st_q.cnt   <= '0;
            st_q.idx   <= '0;
            st_q.frame <= '1;
            st_q.div   <= DIV_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign line_o = st_q.busy ? st_q.frame[0] : 1'b1;
endmodule

// File: rtl/ser_bcast_tx.sv
module ser_bcast_tx
    import ser_bcast_pkg::*;
#(
    parameter int NUM_CH  = 6,
    parameter int ADDR_W  = 3,
    parameter int WORD_W  = 16,
    parameter int DIV_RST = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [NUM_CH-1:0] tx_line,
    output logic              tx_busy
);
    localparam int DIV_W = WORD_W;

    typedef struct packed {
        logic [NUM_CH-1:0] sel;
        logic              pend_v;
        logic [NUM_CH-1:0] pend_sel;
        logic [BYTE_W-1:0] pend_data;
    } top_t;

    top_t st_d, st_q;

    logic [NUM_CH-1:0][DIV_W-1:0] div_all;
    logic [DIV_W-1:0]  launch_div;
    logic [NUM_CH-1:0] wr_sel, launch_sel;
    logic [BYTE_W-1:0] launch_data;
    logic              wr_go, launch, eng_busy, eng_done, eng_line, slot_free;
    logic              unused_hi;

    assign wr_sel    = wr_data[SEL_LSB +: NUM_CH];
    assign wr_go     = wr_en && (wr_addr == '0) && (|wr_sel);
    assign unused_hi = ^wr_data[WORD_W-1:SEL_LSB+NUM_CH];

    sbt_baud_bank #(
        .NUM_CH(NUM_CH), .DIV_W(DIV_W), .ADDR_W(ADDR_W), .DIV_RST(DIV_RST)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data[DIV_W-1:0]), .div_o(div_all)
    );

    sbt_div_pick #(.NUM_CH(NUM_CH), .DIV_W(DIV_W)) u_pick (
        .sel_i(launch_sel), .div_i(div_all), .div_o(launch_div)
    );

    sbt_shift_eng #(.DIV_W(DIV_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .start_i(launch), .data_i(launch_data),
        .div_i(launch_div), .busy_o(eng_busy), .done_o(eng_done), .line_o(eng_line)
    );

    always_comb begin
        st_d        = st_q;
        slot_free   = !eng_busy || eng_done;
        launch      = 1'b0;
        launch_sel  = wr_sel;
        launch_data = wr_data[BYTE_W-1:0];
        if (slot_free && st_q.pend_v) begin
            launch       = 1'b1;
            launch_sel   = st_q.pend_sel;
            launch_data  = st_q.pend_data;
            st_d.pend_v  = wr_go;
            if (wr_go) begin
                st_d.pend_sel  = wr_sel;
                st_d.pend_data = wr_data[BYTE_W-1:0];
            end
        end else if (slot_free && wr_go) begin
            launch = 1'b1;
        end else if (wr_go && !st_q.pend_v) begin
            st_d.pend_v    = 1'b1;
            st_d.pend_sel  = wr_sel;
            st_d.pend_data = wr_data[BYTE_W-1:0];
        end
        if (launch) begin
            st_d.sel = launch_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_gate
            assign tx_line[g] = st_q.sel[g] ? eng_line : 1'b1;
        end
    endgenerate

    assign tx_busy = eng_busy;

    logic [NUM_CH-1:0] sel_vec;
    logic              pend_valid;
    assign sel_vec    = st_q.sel;
    assign pend_valid = st_q.pend_v;
endmodule

// File: rtl/ser_bcast_tx_chk.sv
module ser_bcast_tx_chk #(
    parameter int NUM_CH = 6,
    parameter int ADDR_W = 3,
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [WORD_W-1:0] wr_data,
    input logic [NUM_CH-1:0] tx_line,
    input logic              tx_busy,
    input logic [NUM_CH-1:0] sel_vec,
    input logic              pend_valid
);
    logic [NUM_CH-1:0] wsel;
    logic              tx_wr;
    assign wsel  = wr_data[8 +: NUM_CH];
    assign tx_wr = wr_en && (wr_addr == '0);

    assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> (tx_line == '1));

    assert_unsel_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_line | sel_vec) == '1));

    assert_lines_agree_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_line & sel_vec) == '0) || ((tx_line & sel_vec) == sel_vec));

    assert_start_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && (|wsel) && !tx_busy) |=> (tx_busy && ((tx_line & $past(wsel)) == '0)));

    assert_zero_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && (wsel == '0) && !tx_busy) |=> (!tx_busy && !pend_valid));

    assert_no_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_busy) |-> !$past(pend_valid));
endmodule

bind ser_bcast_tx ser_bcast_tx_chk #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .WORD_W(WORD_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_line(tx_line), .tx_busy(tx_busy), .sel_vec(sel_vec), .pend_valid(pend_valid)
);

// File: tb/ser_bcast_tx_test.sv
module ser_bcast_tx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [5:0]  tx_line;
    logic        tx_busy;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    ser_bcast_tx uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tx_line(tx_line), .tx_busy(tx_busy)
    );

    task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; wr_addr = '0;
    endtask

    // Starts in the first cycle of the frame; ends one cycle after the stop bit.
    task automatic check_frame(input string req, input logic [5:0] sel,
                               input logic [7:0] data, input int dv, input bit idle_after);
        for (int b = 0; b < 10; b++) begin
            logic bv;
            bv = (b == 0) ? 1'b0 : (b == 9) ? 1'b1 : data[b-1];
            chk(req, {tx_busy, tx_line}, {1'b1, (sel & {6{bv}}) | ~sel});
            repeat (dv - 1) @(negedge clk);
            chk(req, {tx_busy, tx_line}, {1'b1, (sel & {6{bv}}) | ~sel});
            @(negedge clk);
        end
        if (idle_after) chk({req, " R7 end"}, {tx_busy, tx_line}, 7'b0111111);
    endtask

    task automatic t_reset;
        chk("R11 reset", {tx_busy, tx_line}, 7'b0111111);
    endtask

    task automatic t_default_div;
        wr(3'd0, 16'h1000 | 16'h00C3);
        check_frame("R11 default divider", 6'b010000, 8'hC3, 16, 1'b1);
    endtask

    task automatic t_single;
        wr(3'd1, 16'd4);
        wr(3'd0, 16'h0100 | 16'h00A5);
        check_frame("R1 R4 single line", 6'b000001, 8'hA5, 4, 1'b1);
    endtask

    task automatic t_top_bits;
        wr(3'd6, 16'd3);
        wr(3'd0, 16'hE000 | 16'h003C);
        check_frame("R3 R5 high bits ignored", 6'b100000, 8'h3C, 3, 1'b1);
    endtask

    task automatic t_multi;
        wr(3'd2, 16'd8);
        wr(3'd4, 16'd5);
        wr(3'd5, 16'd6);
        wr(3'd0, 16'h1A00 | 16'h0081);
        check_frame("R6 R2 multi line", 6'b011010, 8'h81, 5, 1'b1);
    endtask

    task automatic t_div_zero;
        wr(3'd3, 16'd0);
        wr(3'd0, 16'h0400 | 16'h005A);
        check_frame("R5 zero divider", 6'b000100, 8'h5A, 1, 1'b1);
    endtask

    task automatic t_zero_mask;
        wr(3'd0, 16'h00FF);
        for (int i = 0; i < 8; i++) begin
            chk("R10 zero mask", {tx_busy, tx_line}, 7'b0111111);
            @(negedge clk);
        end
    endtask

    task automatic t_hold_drop;
        wr(3'd2, 16'd2);
        wr(3'd0, 16'h0100 | 16'h0066);
        fork
            check_frame("R8 first frame", 6'b000001, 8'h66, 4, 1'b0);
            begin
                wr(3'd0, 16'h0200 | 16'h000F);
                wr(3'd0, 16'h0077);
                wr(3'd0, 16'h0400 | 16'h00FF);
            end
        join
        check_frame("R8 held frame", 6'b000010, 8'h0F, 2, 1'b1);
        for (int i = 0; i < 20; i++) begin
            chk("R9 dropped write", {tx_busy, tx_line}, 7'b0111111);
            @(negedge clk);
        end
    endtask

    task automatic t_div_change;
        wr(3'd0, 16'h0100 | 16'h00B4);
        fork
            check_frame("R12 divider change mid-frame", 6'b000001, 8'hB4, 4, 1'b1);
            begin
                repeat (3) @(negedge clk);
                wr(3'd1, 16'd9);
            end
        join
        wr(3'd0, 16'h0100 | 16'h0011);
        check_frame("R12 new divider next frame", 6'b000001, 8'h11, 9, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_default_div();
        t_single();
        t_top_bits();
        t_multi();
        t_div_zero();
        t_zero_mask();
        t_hold_drop();
        t_div_change();
        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule